// File: doc/BRIEF.md
# Multi-Mode Load Address Generator

This block turns one load request into the address to read and, for the pointer-updating modes, the next value of the pointer register. It supports eight addressing modes, each usable with byte or halfword accesses. The modes are: base plus offset, scaled index plus absolute base, absolute-with-pointer-set, two plain post-increment forms, bit-reversed post-increment, and two circular-buffer post-increment forms. It sits between the register read stage and the data memory port of a load unit. The memory and the load data path lie outside the block.

A request is presented with `in_valid` high. One clock edge later, `out_valid` rises together with the effective address, the updated pointer and the writeback enable. All arithmetic is 32-bit unsigned and wraps modulo 2^32.

The circular modes take the buffer start from a dedicated register and the buffer length from the low bits of the modifier. The register-increment circular mode packs its increment into the modifier as well. The block then scales that increment by the access size.

Top module: `ld_addr_gen`

## Requirements
- R1: While reset is asserted and on the first edge after it, `out_valid` and `out_wb` are 0.
- R2: Mode 0 (offset): `out_ea` = `in_ptr` + `in_imm`, `out_wb` = 0.
- R3: Mode 1 (scaled index): `out_ea` = (`in_index` << `in_shamt`) + `in_imm`, `out_wb` = 0.
- R4: Mode 2 (absolute set): `out_ea` = `in_imm`, `out_ptr` = `in_imm`, `out_wb` = 1.
- R5: Modes 3 and 4 (post-increment by immediate / by modifier): `out_ea` = `in_ptr`, `out_ptr` = `in_ptr` + `in_imm` (mode 3) or + `in_mod` (mode 4), `out_wb` = 1.
- R6: Mode 5 (bit-reversed): `out_ea` keeps bits 31:16 of `in_ptr` and holds bits 15:0 of `in_ptr` in reversed order (bit i goes to bit 15-i). `out_ptr` = `in_ptr` + `in_mod`, and `out_wb` = 1.
- R7: Mode 6 (circular, immediate increment in bytes): `out_ea` = `in_ptr`, `out_wb` = 1, L = `in_mod[16:0]`, and `out_ptr` = `in_cstart` + ((`in_ptr` - `in_cstart` + `in_imm`) mod L). This holds when the pointer lies inside the buffer and the increment is below L.
- R8: Mode 7 (circular, packed increment): the increment is `in_mod[23:17]`, doubled when `in_half` = 1, and L = `in_mod[16:0]`. Otherwise it behaves as R7.
- R9: In modes 6 and 7, a length of 0 disables the wrap, so `out_ptr` = `in_ptr` + increment.
- R10: With `in_valid` low, the next edge clears `out_valid` and `out_wb` and leaves `out_ea` and `out_ptr` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_mode | input | 3 | Addressing mode 0..7 |
| in_half | input | 1 | 1 = halfword access, 0 = byte access |
| in_ptr | input | 32 | Base / pointer register value |
| in_index | input | 32 | Index register for scaled mode |
| in_shamt | input | 2 | Index shift amount |
| in_imm | input | 32 | Immediate: offset, absolute address or increment |
| in_mod | input | 32 | Modifier register |
| in_cstart | input | 32 | Circular buffer start |
| out_valid | output | 1 | Result present |
| out_ea | output | 32 | Effective address |
| out_ptr | output | 32 | Updated pointer value |
| out_wb | output | 1 | Pointer writeback enable |

## Verification
The circular modes deliver the old pointer as the address and wrap the new pointer in the same cycle. The bench provokes this by walking a pointer to the last element of short buffers: length 2, 4 and 5, with byte and halfword steps. It then checks both outputs of that one result against sequences of offsets computed in the bench. The bit-reversed mode pairs a reversed address with a plain add on the same request. It is judged over four chained steps whose addresses must land on offsets 0, 4, 2 and 6.

// File: rtl/ld_addr_gen.sv
module ld_addr_gen #(
  parameter int AW    = 32,
  parameter int LEN_W = 17,
  parameter int INC_W = 7,
  parameter int REV_W = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [2:0]    in_mode,
  input  logic          in_half,
  input  logic [AW-1:0] in_ptr,
  input  logic [AW-1:0] in_index,
  input  logic [1:0]    in_shamt,
  input  logic [AW-1:0] in_imm,
  input  logic [AW-1:0] in_mod,
  input  logic [AW-1:0] in_cstart,
  output logic          out_valid,
  output logic [AW-1:0] out_ea,
  output logic [AW-1:0] out_ptr,
  output logic          out_wb
);

  localparam logic [2:0] M_OFFS = 3'd0;
  localparam logic [2:0] M_SIDX = 3'd1;
  localparam logic [2:0] M_ASET = 3'd2;
  localparam logic [2:0] M_PIMM = 3'd3;
  localparam logic [2:0] M_PMOD = 3'd4;
  localparam logic [2:0] M_BREV = 3'd5;
  localparam logic [2:0] M_CIMM = 3'd6;
  localparam logic [2:0] M_CREG = 3'd7;

  logic [AW-1:0]    len_c, creg_inc, cinc, rel, csum, cwrap, circ_np;
  logic [REV_W-1:0] rev_lo;
  logic [AW-1:0]    ea_c, np_c;
  logic             wb_c;
  logic [2:0]       mode_q;

  assign len_c    = AW'(in_mod[LEN_W-1:0]);
  assign creg_inc = AW'(in_mod[LEN_W+INC_W-1:LEN_W]) << in_half;
  assign cinc     = (in_mode == M_CREG) ? creg_inc : in_imm;
  assign rel      = in_ptr - in_cstart;
  assign csum     = rel + cinc;
  assign cwrap    = (len_c != '0 && csum >= len_c) ? csum - len_c : csum;
  assign circ_np  = in_cstart + cwrap;

  for (genvar i = 0; i < REV_W; i++) begin : g_rev
    assign rev_lo[i] = in_ptr[REV_W-1-i];
  end

  always_comb begin
    ea_c = in_ptr;
    np_c = in_ptr;
    wb_c = 1'b1;
    case (in_mode)
      M_OFFS: begin ea_c = in_ptr + in_imm; wb_c = 1'b0; end
      M_SIDX: begin ea_c = (in_index << in_shamt) + in_imm; wb_c = 1'b0; end
      M_ASET: begin ea_c = in_imm; np_c = in_imm; end
      M_PIMM: np_c = in_ptr + in_imm;
      M_PMOD: np_c = in_ptr + in_mod;
      M_BREV: begin ea_c = {in_ptr[AW-1:REV_W], rev_lo}; np_c = in_ptr + in_mod; end
      M_CIMM, M_CREG: np_c = circ_np;
      default: wb_c = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_wb    <= 1'b0;
      out_ea    <= '0;
      out_ptr   <= '0;
      mode_q    <= M_OFFS;
    end else begin
      out_valid <= in_valid;
      out_wb    <= in_valid & wb_c;
      if (in_valid) begin
        out_ea  <= ea_c;
        out_ptr <= np_c;
        mode_q  <= in_mode;
      end
    end
  end

  p_wb_needs_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_wb |-> out_valid);

  p_no_wb_addr_modes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (mode_q == M_OFFS || mode_q == M_SIDX) |-> !out_wb);

  p_aset_ptr_is_ea_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && mode_q == M_ASET |-> out_wb && out_ptr == out_ea);

  p_postinc_old_ptr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid) && out_valid && (mode_q == M_PIMM || mode_q == M_PMOD ||
      mode_q == M_CIMM || mode_q == M_CREG) |-> out_ea == $past(in_ptr));

  p_brev_upper_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid) && out_valid && mode_q == M_BREV
      |-> out_ea[AW-1:REV_W] == $past(in_ptr[AW-1:REV_W]));

  p_circ_in_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid) && out_valid && mode_q == M_CIMM && $past(len_c) != '0 &&
      ($past(in_ptr) - $past(in_cstart)) < $past(len_c) && $past(in_imm) < $past(len_c)
      |-> (out_ptr - $past(in_cstart)) < $past(len_c));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(in_valid) |-> !out_valid && $stable(out_ea) && $stable(out_ptr));

endmodule

// File: tb/test_ld_addr_gen.sv
module test_ld_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  in_mode = '0;
  logic        in_half = 1'b0;
  logic [31:0] in_ptr = '0, in_index = '0, in_imm = '0, in_mod = '0, in_cstart = '0;
  logic [1:0]  in_shamt = '0;
  logic        out_valid, out_wb;
  logic [31:0] out_ea, out_ptr;
  int checks = 0, failures = 0;
  bit done = 0;
  localparam logic [31:0] BUF = 32'h0001_0000;

  always #2 clk = ~clk;

  ld_addr_gen i_ld_addr_gen (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] m, input logic [31:0] p, input logic [31:0] imm,
                      input logic [31:0] md, input logic h);
    in_valid = 1'b1; in_mode = m; in_ptr = p; in_imm = imm; in_mod = md; in_half = h;
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 valid in reset", {31'd0, out_valid}, 32'd0);
    chk("R1 wb in reset", {31'd0, out_wb}, 32'd0);
  endtask

  task automatic t_offset;
    for (int k = 0; k < 4; k++) begin
      step(3'd0, BUF, 32'(2 * k), 32'hFFFF_FFFF, 1'b1);
      chk("R2 ea", out_ea, BUF + 32'(2 * k));
      chk("R2 wb", {31'd0, out_wb}, 32'd0);
    end
    step(3'd0, 32'hFFFF_FFFE, 32'd5, '0, 1'b0);
    chk("R2 ea wrap", out_ea, 32'd3);
  endtask

  task automatic t_scaled;
    for (int k = 0; k < 4; k++) begin
      in_index = 32'(k); in_shamt = 2'd1;
      step(3'd1, 32'hDEAD_0000, BUF, '0, 1'b0);
      chk("R3 ea shift1", out_ea, BUF + 32'(2 * k));
      chk("R3 wb", {31'd0, out_wb}, 32'd0);
    end
    in_index = 32'd5; in_shamt = 2'd3;
    step(3'd1, '0, BUF, '0, 1'b0);
    chk("R3 ea shift3", out_ea, BUF + 32'd40);
  endtask

  task automatic t_absset;
    for (int k = 0; k < 4; k++) begin
      step(3'd2, 32'h1234_5678, BUF + 32'(k), '0, 1'b0);
      chk("R4 ea", out_ea, BUF + 32'(k));
      chk("R4 ptr", out_ptr, BUF + 32'(k));
      chk("R4 wb", {31'd0, out_wb}, 32'd1);
    end
  endtask

  task automatic t_postinc;
    logic [31:0] p = BUF;
    for (int k = 0; k < 4; k++) begin
      step(3'd3, p, 32'd2, 32'd9, 1'b1);
      chk("R5 imm ea", out_ea, BUF + 32'(2 * k));
      chk("R5 imm ptr", out_ptr, BUF + 32'(2 * k + 2));
      chk("R5 imm wb", {31'd0, out_wb}, 32'd1);
      p = out_ptr;
    end
    p = BUF;
    for (int k = 0; k < 4; k++) begin
      step(3'd4, p, 32'd7, 32'd1, 1'b0);
      chk("R5 mod ea", out_ea, BUF + 32'(k));
      chk("R5 mod ptr", out_ptr, BUF + 32'(k + 1));
      p = out_ptr;
    end
  endtask

  task automatic t_brev;
    logic [31:0] p = BUF;
    logic [31:0] offs [4] = '{32'd0, 32'd4, 32'd2, 32'd6};
    for (int k = 0; k < 4; k++) begin
      step(3'd5, p, '0, 32'h0000_2000, 1'b0);
      chk("R6 brev ea", out_ea, BUF + offs[k]);
      chk("R6 brev ptr", out_ptr, BUF + 32'(k + 1) * 32'h2000);
      chk("R6 wb", {31'd0, out_wb}, 32'd1);
      p = out_ptr;
    end
    step(3'd5, 32'hABCD_0001, '0, '0, 1'b0);
    chk("R6 brev msb", out_ea, 32'hABCD_8000);
  endtask

  task automatic t_circ_imm;
    logic [31:0] p = BUF;
    in_cstart = BUF;
    for (int k = 0; k < 4; k++) begin
      step(3'd6, p, 32'd1, 32'd2, 1'b0);
      chk("R7 len2 ea", out_ea, BUF + 32'(k % 2));
      chk("R7 len2 ptr", out_ptr, BUF + 32'((k + 1) % 2));
      p = out_ptr;
    end
    p = BUF;
    for (int k = 0; k < 4; k++) begin
      step(3'd6, p, 32'd2, 32'hFFFE_0004, 1'b1);
      chk("R7 len4 ptr", out_ptr, BUF + 32'((2 * k + 2) % 4));
      chk("R7 wb", {31'd0, out_wb}, 32'd1);
      p = out_ptr;
    end
  endtask

  task automatic t_circ_reg;
    logic [31:0] p = BUF;
    in_cstart = BUF;
    for (int k = 0; k < 4; k++) begin
      step(3'd7, p, 32'd99, (32'd1 << 17) | 32'd4, 1'b1);
      chk("R8 half ea", out_ea, BUF + 32'((2 * k) % 4));
      chk("R8 half ptr", out_ptr, BUF + 32'((2 * k + 2) % 4));
      p = out_ptr;
    end
    p = BUF;
    for (int k = 0; k < 5; k++) begin
      step(3'd7, p, '0, (32'd3 << 17) | 32'd5, 1'b0);
      chk("R8 byte ptr", out_ptr, BUF + 32'((3 * k + 3) % 5));
      p = out_ptr;
    end
  endtask

  task automatic t_len0;
    in_cstart = BUF;
    step(3'd6, BUF + 32'd8, 32'd5, '0, 1'b0);
    chk("R9 imm len0", out_ptr, BUF + 32'd13);
    step(3'd7, BUF, '0, 32'd6 << 17, 1'b1);
    chk("R9 reg len0", out_ptr, BUF + 32'd12);
  endtask

  task automatic t_idle;
    step(3'd2, '0, 32'h0000_0ABC, '0, 1'b0);
    in_valid = 1'b0; in_mode = 3'd2; in_imm = 32'h5555_0000;
    @(posedge clk); #1;
    chk("R10 valid", {31'd0, out_valid}, 32'd0);
    chk("R10 wb", {31'd0, out_wb}, 32'd0);
    chk("R10 ea held", out_ea, 32'h0000_0ABC);
    chk("R10 ptr held", out_ptr, 32'h0000_0ABC);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 t_reset();
    rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_offset();
    t_scaled();
    t_absset();
    t_postinc();
    t_brev();
    t_circ_imm();
    t_circ_reg();
    t_len0();
    t_idle();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule